// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Responder

This block answers configuration cycles for a small serial controller. It holds the constant part of a type-0 header: identity dwords, class code, revision, command and status. It also holds the few registers software may change: one or two I/O base-address registers and the interrupt-line byte. An upstream bus adapter turns configuration transactions into single-cycle requests. Each request carries a dword index, byte enables, write data and a direction bit. The block acknowledges every request exactly one cycle later and returns a full dword on reads.

The base-address registers follow the standard sizing handshake. A full-dword write of all ones leaves the size mask in the register. Any other write stores the address. The two type bits at the bottom never change. The parameter `NUM_PORTS` picks the variant. With one port the second base register is a hard zero. With two ports it is a second live 8-byte I/O window.

The control path is a two-state machine. `ST_IDLE` waits for a strobe. The transition *accept* (strobe seen in `ST_IDLE`) commits any write and captures any read data, then moves to `ST_ACK`. `ST_ACK` drives the acknowledge for one cycle. Its only transition, *release*, returns unconditionally to `ST_IDLE`, and a strobe seen in `ST_ACK` is ignored.

Top module: `cfg_hdr_resp`

## Requirements
- R1: After reset, `ack` and `rdata` are zero, BAR0 reads 0x00000001, the interrupt line (byte 0 of dword 0x0F) reads 0x00, and BAR1 reads 0x00000001 when NUM_PORTS is 2.
- R2: Dword index 0x00 and dword index 0x0B (byte offset 0x2C) both read 0x32534348 at all times.
- R3: Dword 0x01 reads 0x02000001: command 0x0001 in bits [15:0] and status 0x0200 in bits [31:16]. Writes to it are discarded. Dword 0x02 reads 0x07000210: revision 0x10 in [7:0], programming interface 0x02 in [15:8], subclass 0x00 in [23:16] and base class 0x07 in [31:24].
- R4: A strobe accepted in `ST_IDLE` gives `ack` high for exactly the next cycle, with read data valid in that cycle. A strobe present while `ack` is high is ignored. `rdata` is zero whenever `ack` is low or the request was a write.
- R5: A write to BAR0 (dword 0x04) with all four byte enables and data 0xFFFFFFFF makes it read the size mask with the type bits kept. For the default 8-byte window this is 0xFFFFFFF8 | old[1:0], i.e. 0xFFFFFFF9.
- R6: Any other BAR write, including all-ones data with fewer than four byte enables, merges the enabled bytes of `wdata` (byte n is `be[n]`) into the stored value. Bits [1:0] always keep their previous contents.
- R7: With NUM_PORTS = 2, BAR1 (dword 0x05) behaves exactly as BAR0. With NUM_PORTS = 1, it reads zero after any write.
- R8: Dwords 0x06, 0x07 and 0x08 (BAR2 to BAR4) read zero, including after any write.
- R9: Byte 0 of dword 0x0F is the read/write interrupt line, written when `be[0]` is set. Byte 1 reads 0x01 and ignores writes. Bytes 2 and 3 read zero.
- R10: Every other dword index, including 0x0D (capability pointer) and all indices from 0x10 upward, reads zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strb | input | 1 | Request strobe, sampled in `ST_IDLE` |
| wr | input | 1 | 1 = write request, 0 = read request |
| cfg_dw_addr | input | 6 | Dword index into the 256-byte header space |
| be | input | 4 | Byte enables for writes |
| wdata | input | 32 | Write data |
| ack | output | 1 | Acknowledge, high for one cycle per accepted request |
| rdata | output | 32 | Read data, valid while `ack` is high after a read |

## Verification
Three situations are hard to reach from the ports. The first is a request overlapping the acknowledge cycle. The bench holds the strobe high for two cycles and changes the write data between them, so only the first value should reach the interrupt-line register. The second is the difference between a sizing probe and a partial all-ones write. The bench sweeps all sixteen byte-enable patterns with all-ones data into BAR0. The third is the one-port variant. A second instance with `NUM_PORTS` = 1 gets the same stimulus, and its BAR1 must stay zero while the two-port copy tracks every write.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } cfg_state_e;

    localparam int DW_IDX_W = 6;

    localparam logic [DW_IDX_W-1:0] IDX_IDENT  = 6'h00;
    localparam logic [DW_IDX_W-1:0] IDX_CMDSTS = 6'h01;
    localparam logic [DW_IDX_W-1:0] IDX_CLASS  = 6'h02;
    localparam logic [DW_IDX_W-1:0] IDX_BAR0   = 6'h04;
    localparam logic [DW_IDX_W-1:0] IDX_BAR1   = 6'h05;
    localparam logic [DW_IDX_W-1:0] IDX_SUBSYS = 6'h0B;
    localparam logic [DW_IDX_W-1:0] IDX_INTR   = 6'h0F;

    localparam logic [31:0] IDENT_WORD  = 32'h3253_4348;
    localparam logic [31:0] CMDSTS_WORD = 32'h0200_0001;
    localparam logic [31:0] CLASS_WORD  = 32'h0700_0210;
    localparam logic [31:0] BAR_RESET   = 32'h0000_0001;
    localparam logic [7:0]  INT_PIN_A   = 8'h01;

    function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                                input logic [31:0] new_v,
                                                input logic [3:0]  lanes);
        logic [31:0] res;
        for (int b = 0; b < 4; b++) begin
            res[b*8 +: 8] = lanes[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/cfg_hdr_bar.sv
module cfg_hdr_bar
    import cfg_hdr_pkg::*;
#(
    parameter int WINDOW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] value
);
    localparam logic [31:0] SIZE_MASK = 32'(0) - 32'(WINDOW);

    logic [31:0] bar_q;
    logic [31:0] merged;
    logic        probe;

    always_comb begin
        merged = merge_bytes(bar_q, wdata, be);
        probe  = (be == 4'hF) && (wdata == 32'hFFFF_FFFF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_q <= BAR_RESET;
        end else if (wr_en) begin
            if (probe) begin
                bar_q <= {SIZE_MASK[31:2], bar_q[1:0]};
            end else begin
                bar_q <= {merged[31:2], bar_q[1:0]};
            end
        end
    end

    assign value = bar_q;

    assert_type_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(bar_q[1:0]));

    assert_probe_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && be == 4'hF && wdata == 32'hFFFF_FFFF) |=> (bar_q[31:2] == SIZE_MASK[31:2]));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bar_q));

endmodule

// File: rtl/cfg_hdr_rdmux.sv
module cfg_hdr_rdmux
    import cfg_hdr_pkg::*;
(
    input  logic [DW_IDX_W-1:0] idx,
    input  logic [31:0]         bar0,
    input  logic [31:0]         bar1,
    input  logic [7:0]          int_line,
    output logic [31:0]         dword
);
    always_comb begin
        unique case (idx)
            IDX_IDENT:  dword = IDENT_WORD;
            IDX_CMDSTS: dword = CMDSTS_WORD;
            IDX_CLASS:  dword = CLASS_WORD;
            IDX_BAR0:   dword = bar0;
            IDX_BAR1:   dword = bar1;
            IDX_SUBSYS: dword = IDENT_WORD;
            IDX_INTR:   dword = {16'h0000, INT_PIN_A, int_line};
            default:    dword = 32'h0000_0000;
        endcase
    end
endmodule

// File: rtl/cfg_hdr_resp.sv
module cfg_hdr_resp
    import cfg_hdr_pkg::*;
#(
    parameter int NUM_PORTS  = 2,
    parameter int BAR_WINDOW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strb,
    input  logic        wr,
    input  logic [5:0]  cfg_dw_addr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic        ack,
    output logic [31:0] rdata
);
    cfg_state_e state_q, state_d;

    logic        accept;
    logic        wr_acc;
    logic        rd_q;
    logic [5:0]  idx_q;
    logic [31:0] rdata_q;
    logic [31:0] bar0_v, bar1_v, mux_v;
    logic [7:0]  int_line_q;

    assign accept = strb && (state_q == ST_IDLE);
    assign wr_acc = accept && wr;

    // state register and transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (strb) state_d = ST_ACK;   // accept
            ST_ACK:  state_d = ST_IDLE;            // release
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            rd_q    <= 1'b0;
            idx_q   <= '0;
        end else if (accept) begin
            rdata_q <= wr ? 32'h0 : mux_v;
            rd_q    <= !wr;
            idx_q   <= cfg_dw_addr;
        end else begin
            rdata_q <= '0;
            rd_q    <= 1'b0;
        end
    end

    assign ack   = (state_q == ST_ACK);
    assign rdata = ack ? rdata_q : 32'h0;

    // interrupt line byte
    always_ff @(posedge clk) begin
        if (!rst_n)                                          int_line_q <= 8'h00;
        else if (wr_acc && cfg_dw_addr == IDX_INTR && be[0]) int_line_q <= wdata[7:0];
    end

    cfg_hdr_bar #(.WINDOW(BAR_WINDOW)) u_bar0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_acc && cfg_dw_addr == IDX_BAR0),
        .be(be), .wdata(wdata), .value(bar0_v)
    );

    generate
        if (NUM_PORTS >= 2) begin : g_bar1_live
            cfg_hdr_bar #(.WINDOW(BAR_WINDOW)) u_bar1 (
                .clk(clk), .rst_n(rst_n),
                .wr_en(wr_acc && cfg_dw_addr == IDX_BAR1),
                .be(be), .wdata(wdata), .value(bar1_v)
            );
        end else begin : g_bar1_absent
            assign bar1_v = 32'h0;
        end
    endgenerate

    cfg_hdr_rdmux u_rdmux (
        .idx(cfg_dw_addr), .bar0(bar0_v), .bar1(bar1_v),
        .int_line(int_line_q), .dword(mux_v)
    );

    assert_ack_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && !ack) |=> ack);

    assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_rdata_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> (rdata == 32'h0));

    assert_ident_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && rd_q && (idx_q == IDX_IDENT || idx_q == IDX_SUBSYS)) |-> (rdata == IDENT_WORD));

    assert_pin_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && rd_q && idx_q == IDX_INTR) |-> (rdata[31:8] == 24'h000001));

    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && rd_q && idx_q >= 6'h10) |-> (rdata == 32'h0));

endmodule

// File: tb/cfg_hdr_resp_tb_top.sv
module cfg_hdr_resp_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strb = 1'b0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic        ack2, ack1;
    logic [31:0] rd2, rd1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_b0 [2];
    logic [31:0] m_b1 [2];
    logic [7:0]  m_il [2];

    always #2 clk = ~clk;

    cfg_hdr_resp #(.NUM_PORTS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .strb(strb), .wr(wr), .cfg_dw_addr(addr),
        .be(be), .wdata(wdata), .ack(ack2), .rdata(rd2));

    cfg_hdr_resp #(.NUM_PORTS(1)) dut1_i (
        .clk(clk), .rst_n(rst_n), .strb(strb), .wr(wr), .cfg_dw_addr(addr),
        .be(be), .wdata(wdata), .ack(ack1), .rdata(rd1));

    function automatic string tag_of(input int idx);
        case (idx)
            0, 11:    return "R2";
            1, 2:     return "R3";
            4:        return "R5/R6";
            5:        return "R7";
            6, 7, 8:  return "R8";
            15:       return "R9";
            default:  return "R10";
        endcase
    endfunction

    function automatic logic [31:0] expect_rd(input int d, input int idx);
        case (idx)
            0, 11:   return 32'h3253_4348;
            1:       return 32'h0200_0001;
            2:       return 32'h0700_0210;
            4:       return m_b0[d];
            5:       return m_b1[d];
            15:      return {16'h0, 8'h01, m_il[d]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] bar_next(input logic [31:0] old_v, input logic [3:0] b,
                                             input logic [31:0] w);
        logic [31:0] m;
        if (b == 4'hF && w == 32'hFFFF_FFFF) return 32'hFFFF_FFF8 | {30'h0, old_v[1:0]};
        for (int k = 0; k < 4; k++) m[k*8 +: 8] = b[k] ? w[k*8 +: 8] : old_v[k*8 +: 8];
        return {m[31:2], old_v[1:0]};
    endfunction

    task automatic model_write(input int idx, input logic [3:0] b, input logic [31:0] w);
        for (int d = 0; d < 2; d++) begin
            if (idx == 4) m_b0[d] = bar_next(m_b0[d], b, w);
            if (idx == 5 && d == 0) m_b1[d] = bar_next(m_b1[d], b, w);
            if (idx == 15 && b[0]) m_il[d] = w[7:0];
        end
    endtask

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    task automatic do_access(input bit w, input int idx, input logic [3:0] b,
                             input logic [31:0] d);
        @(negedge clk);
        strb = 1'b1; wr = w; addr = 6'(idx); be = b; wdata = d;
        @(negedge clk);
        strb = 1'b0;
        check("R4", "ack 2p", {31'h0, ack2}, 32'h1);
        check("R4", "ack 1p", {31'h0, ack1}, 32'h1);
        if (!w) begin
            check(tag_of(idx), $sformatf("2p read idx %0d", idx), rd2, expect_rd(0, idx));
            check(tag_of(idx), $sformatf("1p read idx %0d", idx), rd1, expect_rd(1, idx));
        end else begin
            check("R4", "rdata on write", rd2, 32'h0);
            model_write(idx, b, d);
        end
        @(negedge clk);
        check("R4", "ack drop", {31'h0, ack2}, 32'h0);
    endtask

    task automatic read_all();
        for (int i = 0; i < 64; i++) do_access(1'b0, i, 4'h0, 32'h0);
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            m_b0[d] = 32'h1; m_il[d] = 8'h0;
        end
        m_b1[0] = 32'h1; m_b1[1] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "ack after reset", {31'h0, ack2}, 32'h0);
        check("R1", "rdata after reset", rd2, 32'h0);
        read_all();
        // all-ones full-dword writes everywhere (probe on BARs, R3/R8/R10 discard)
        for (int i = 0; i < 64; i++) do_access(1'b1, i, 4'hF, 32'hFFFF_FFFF);
        read_all();
        // patterned writes everywhere
        for (int i = 0; i < 64; i++)
            do_access(1'b1, i, 4'hF, 32'hA55A_3C00 ^ (32'(i) * 32'h0101_0101));
        read_all();
        // R6: every byte-enable pattern, all-ones data (no probe unless all four lanes)
        for (int b = 0; b < 16; b++) begin
            do_access(1'b1, 4, 4'hF, 32'h0000_0000);
            do_access(1'b1, 4, 4'(b), 32'hFFFF_FFFF);
            do_access(1'b0, 4, 4'h0, 32'h0);
            do_access(1'b1, 5, 4'(b), 32'h1234_5678 ^ 32'(b));
            do_access(1'b0, 5, 4'h0, 32'h0);
            do_access(1'b1, 15, 4'(b), 32'hFFFF_FF00 | 32'(b * 16 + 3));
            do_access(1'b0, 15, 4'h0, 32'h0);
        end
        // R4: strobe held into the ack cycle is ignored
        @(negedge clk);
        strb = 1'b1; wr = 1'b1; addr = 6'h0F; be = 4'h1; wdata = 32'h0000_005A;
        @(negedge clk);
        wdata = 32'h0000_00C3;
        @(negedge clk);
        strb = 1'b0;
        check("R4", "no ack after held strobe", {31'h0, ack2}, 32'h0);
        model_write(15, 4'h1, 32'h5A);
        do_access(1'b0, 15, 4'h0, 32'h0);
        check("R4", "held strobe second value dropped", {24'h0, rd2[7:0]}, 32'h0);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule